// File: doc/BRIEF.md
# Horizontal Window-Averaging Pixel Decimator

This block is the coarse, integer stage of a horizontal video scaler. It takes a 4:2:2 pixel stream, one luma sample and one chroma sample per valid cycle, and reduces the horizontal sample count by a programmable integer factor N. For each group of N consecutive samples it adds them up, divides by the group size with a reciprocal multiply rounded to nearest, and emits one averaged sample. A separate fine-phase interpolator placed after this block handles any fractional part of the scaling ratio. Vertical scaling is set independently elsewhere.

Luma uses its own accumulator. Chroma arrives interleaved as Cb, Cr, Cb, Cr, ... from the first sample of each line. Cb and Cr each have their own accumulator, and each is averaged over N samples of its own kind. Every component has its own output valid, so a Cb and a Cr result can appear in the same cycle.

The factor comes from a static configuration input. It is sampled only on the first sample of a line. The first sample of a line clears every partial window. A line-end marker forces any partial window to be averaged over the samples it actually holds.

Top module: `hwin_decimator`

## Requirements
- R1: While rst_n is low at a clock edge, all three output valids are low after that edge.
- R2: The window length is cfg_factor, read on the valid line-start sample and used from that sample onwards; cfg_factor of 0 acts as 1 and values above 65 act as 65.
- R3: A luma result equals the sum of its window's luma samples divided by the window's sample count, rounded to nearest with halves rounded up, limited to 255.
- R4: With a window length of 1, every valid luma sample appears unchanged on out_y.
- R5: A valid sample with in_line_last closes every non-empty window on that sample, and each closed window is averaged over the samples it actually received.
- R6: A valid sample with in_line_start discards all partial sums from earlier samples without producing any output for them.
- R7: Chroma position 0 of a line (the line-start sample) and every even position is Cb, and every odd position is Cr; Cb and Cr are each averaged over windows of N samples of their own kind, with the same rounding as R3.
- R8: A change of cfg_factor after the line-start sample has no effect until the next valid line-start sample.
- R9: Each completed window raises its output valid for exactly one cycle, two rising edges after the valid input cycle that completed it; no valid rises otherwise.
- R10: Cycles with in_valid low change no window and produce no output, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_factor | input | 7 | Requested decimation factor (window length) |
| in_valid | input | 1 | Input sample qualifier |
| in_line_start | input | 1 | Marks the first sample of a line (when in_valid) |
| in_line_last | input | 1 | Marks the last sample of a line (when in_valid) |
| in_luma | input | 8 | Luma sample |
| in_chroma | input | 8 | Interleaved chroma sample (Cb on even positions, Cr on odd) |
| out_y_valid | output | 1 | One-cycle strobe per completed luma window |
| out_y | output | 8 | Averaged luma |
| out_cb_valid | output | 1 | One-cycle strobe per completed Cb window |
| out_cb | output | 8 | Averaged Cb |
| out_cr_valid | output | 1 | One-cycle strobe per completed Cr window |
| out_cr | output | 8 | Averaged Cr |

## Verification
Every result is due two rising edges after the valid input cycle that closes its window: one edge registers the finished sum and count, and the next registers the rounded quotient. This holds for luma, Cb and Cr alike, and for windows closed early by the line-end marker. The bench's reference model runs on each accepted input. It records each expected value with the edge count at which it must appear, and checks outputs on the falling edge. There a valid must match the oldest pending value of its lane at exactly its due edge, and a pending value whose edge passes without a valid counts as a failure. This ordering also confirms that discarded partial windows, idle cycles and mid-line factor changes produce nothing extra.

// File: rtl/hwd_pkg.sv
// Package: shared lane indices and the elaboration-time reciprocal used
// by the divider. Assumes 2*n never exceeds 2^31.
package hwd_pkg;

    localparam int LANE_Y  = 0;
    localparam int LANE_CB = 1;
    localparam int LANE_CR = 2;
    localparam int LANES   = 3;

    // ceil(2^s / (2n)): scaled reciprocal used for round-to-nearest division
    function automatic longint unsigned recip_of(input int unsigned n, input int unsigned s);
        longint unsigned d;
        d = 64'(2 * n);
        return ((64'd1 << s) + d - 64'd1) / d;
    endfunction

endpackage

// File: rtl/hwd_ctrl.sv
// Module: hwd_ctrl
// Line-level control shared by all lanes. Clamps the requested factor,
// latches it on the valid line-start sample, and tracks the Cb/Cr phase
// of the interleaved chroma. Assumes in_line_start/in_line_last matter
// only when in_valid is high.
module hwd_ctrl #(
    parameter int CNT_W   = 7,
    parameter int MAX_WIN = 65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_factor,
    input  logic             in_valid,
    input  logic             in_line_start,
    input  logic             in_line_last,
    output logic [CNT_W-1:0] cfg_win,
    output logic [CNT_W-1:0] win_q,
    output logic             line_clear,
    output logic             line_flush,
    output logic             chroma_is_cr
);

    localparam logic [CNT_W-1:0] WIN_MAX = CNT_W'(MAX_WIN);
    localparam logic [CNT_W-1:0] WIN_ONE = CNT_W'(1);

    logic parity_q;

    // Purpose: map the configured factor into the legal window range
    always_comb begin
        if (cfg_factor == '0)
            cfg_win = WIN_ONE;
        else if (cfg_factor > WIN_MAX)
            cfg_win = WIN_MAX;
        else
            cfg_win = cfg_factor;
    end

    // Purpose: qualify the line markers and decode the chroma phase
    always_comb begin
        line_clear   = in_valid && in_line_start;
        line_flush   = in_valid && in_line_last;
        chroma_is_cr = line_clear ? 1'b0 : parity_q;
    end

    // Purpose: hold the window length for the line and toggle chroma phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= WIN_ONE;
            parity_q <= 1'b0;
        end else begin
            if (line_clear)
                win_q <= cfg_win;
            if (in_valid)
                parity_q <= ~chroma_is_cr;
        end
    end

endmodule

// File: rtl/hwd_lane_acc.sv
// Module: hwd_lane_acc
// One component's window accumulator. Adds accepted samples, closes the
// window when it holds win samples or when the line ends with a non-empty
// window, and hands the finished sum and count on for one cycle. Assumes
// win is between 1 and the maximum window and clear marks a new line.
module hwd_lane_acc #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 7,
    parameter int SUM_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             clear,
    input  logic             flush,
    input  logic [CNT_W-1:0] win,
    input  logic [PIX_W-1:0] sample,
    output logic             done,
    output logic [SUM_W-1:0] done_sum,
    output logic [CNT_W-1:0] done_cnt
);

    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] next_sum;
    logic [CNT_W-1:0] next_cnt;
    logic             close;

    // Purpose: form the running sum and count including this cycle's sample
    always_comb begin
        next_sum = (clear ? '0 : sum_q) + (take ? SUM_W'(sample) : '0);
        next_cnt = (clear ? '0 : cnt_q) + (take ? CNT_W'(1) : '0);
        close    = (take && (next_cnt == win)) || (flush && (next_cnt != '0));
    end

    // Purpose: update the accumulator and publish a completed window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q    <= '0;
            cnt_q    <= '0;
            done     <= 1'b0;
            done_sum <= '0;
            done_cnt <= '0;
        end else begin
            done <= close;
            if (close) begin
                done_sum <= next_sum;
                done_cnt <= next_cnt;
                sum_q    <= '0;
                cnt_q    <= '0;
            end else if (take || clear) begin
                sum_q <= next_sum;
                cnt_q <= next_cnt;
            end
        end
    end

endmodule

// File: rtl/hwd_avg_div.sv
// Module: hwd_avg_div
// Divides a window sum by its sample count, rounding halves up, through
// a multiply by a reciprocal from a table built at elaboration. The
// result is limited to the pixel range. Assumes cnt is 1..MAX_WIN when
// valid is high.
module hwd_avg_div #(
    parameter int PIX_W   = 8,
    parameter int CNT_W   = 7,
    parameter int SUM_W   = 15,
    parameter int MAX_WIN = 65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [SUM_W-1:0] in_sum,
    input  logic [CNT_W-1:0] in_cnt,
    output logic             out_vld,
    output logic [PIX_W-1:0] out_pix
);

    // The numerator 2*sum+cnt has X_W bits, the divisor 2*cnt fits in CNT_W+1
    // bits, and SHIFT keeps numerator times error below one divisor step.
    localparam int X_W    = SUM_W + 1;
    localparam int SHIFT  = X_W + CNT_W + 1;
    localparam int R_W    = SHIFT;
    localparam int P_W    = X_W + R_W;
    localparam int TAB_N  = 1 << CNT_W;
    localparam logic [P_W-1:0] PIX_MAX = P_W'((1 << PIX_W) - 1);

    logic [R_W-1:0] recip_tab [TAB_N];
    logic [X_W-1:0] numer;
    logic [P_W-1:0] prod;
    logic [P_W-1:0] quot;

    // Reciprocal table: legal counts get ceil(2^SHIFT / (2n)), the rest zero
    for (genvar i = 0; i < TAB_N; i++) begin : g_tab
        if (i >= 1 && i <= MAX_WIN) begin : g_on
            assign recip_tab[i] = R_W'(hwd_pkg::recip_of(i, SHIFT));
        end else begin : g_off
            assign recip_tab[i] = '0;
        end
    end

    // Purpose: rounded quotient = floor((2*sum+cnt) * recip / 2^SHIFT)
    always_comb begin
        numer = {in_sum, 1'b0} + X_W'(in_cnt);
        prod  = P_W'(numer) * P_W'(recip_tab[in_cnt]);
        quot  = prod >> SHIFT;
    end

    // Purpose: register the saturated average and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_pix <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_pix <= (quot > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : quot[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/hwin_decimator.sv
// Module: hwin_decimator (top)
// Integer horizontal decimator for a 4:2:2 stream. Three lanes (luma, Cb,
// Cr) each accumulate a window and divide it by its sample count. Every
// result appears two edges after the sample that closes its window.
// Assumes chroma alternates Cb/Cr starting with Cb on the line-start
// sample, and markers are honoured only when in_valid is high.
module hwin_decimator #(
    parameter int PIX_W   = 8,
    parameter int MAX_WIN = 65,
    parameter int CNT_W   = $clog2(MAX_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_factor,
    input  logic             in_valid,
    input  logic             in_line_start,
    input  logic             in_line_last,
    input  logic [PIX_W-1:0] in_luma,
    input  logic [PIX_W-1:0] in_chroma,
    output logic             out_y_valid,
    output logic [PIX_W-1:0] out_y,
    output logic             out_cb_valid,
    output logic [PIX_W-1:0] out_cb,
    output logic             out_cr_valid,
    output logic [PIX_W-1:0] out_cr
);

    import hwd_pkg::*;

    localparam int SUM_W = PIX_W + $clog2(MAX_WIN);

    logic [CNT_W-1:0] cfg_win;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] eff_win;
    logic             line_clear;
    logic             line_flush;
    logic             chroma_is_cr;

    logic             lane_take [LANES];
    logic [PIX_W-1:0] lane_smp  [LANES];
    logic             acc_done  [LANES];
    logic [SUM_W-1:0] acc_sum   [LANES];
    logic [CNT_W-1:0] acc_cnt   [LANES];
    logic             res_vld   [LANES];
    logic [PIX_W-1:0] res_pix   [LANES];

    hwd_ctrl #(
        .CNT_W   (CNT_W),
        .MAX_WIN (MAX_WIN)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_factor    (cfg_factor),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .in_line_last  (in_line_last),
        .cfg_win       (cfg_win),
        .win_q         (win_q),
        .line_clear    (line_clear),
        .line_flush    (line_flush),
        .chroma_is_cr  (chroma_is_cr)
    );

    // Purpose: the line-start sample already uses the newly read factor
    always_comb begin
        eff_win = line_clear ? cfg_win : win_q;
    end

    // Purpose: route samples to lanes by component and chroma phase
    always_comb begin
        lane_take[LANE_Y]  = in_valid;
        lane_take[LANE_CB] = in_valid && !chroma_is_cr;
        lane_take[LANE_CR] = in_valid && chroma_is_cr;
        lane_smp[LANE_Y]   = in_luma;
        lane_smp[LANE_CB]  = in_chroma;
        lane_smp[LANE_CR]  = in_chroma;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        hwd_lane_acc #(
            .PIX_W (PIX_W),
            .CNT_W (CNT_W),
            .SUM_W (SUM_W)
        ) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (lane_take[l]),
            .clear    (line_clear),
            .flush    (line_flush),
            .win      (eff_win),
            .sample   (lane_smp[l]),
            .done     (acc_done[l]),
            .done_sum (acc_sum[l]),
            .done_cnt (acc_cnt[l])
        );

        hwd_avg_div #(
            .PIX_W   (PIX_W),
            .CNT_W   (CNT_W),
            .SUM_W   (SUM_W),
            .MAX_WIN (MAX_WIN)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (acc_done[l]),
            .in_sum  (acc_sum[l]),
            .in_cnt  (acc_cnt[l]),
            .out_vld (res_vld[l]),
            .out_pix (res_pix[l])
        );
    end

    assign out_y_valid  = res_vld[LANE_Y];
    assign out_y        = res_pix[LANE_Y];
    assign out_cb_valid = res_vld[LANE_CB];
    assign out_cb       = res_pix[LANE_CB];
    assign out_cr_valid = res_vld[LANE_CR];
    assign out_cr       = res_pix[LANE_CR];

endmodule

// File: rtl/hwin_decimator_chk.sv
// Module: hwin_decimator_chk
// Property checker bound to hwin_decimator. It observes the ports and
// the latched window length.
module hwin_decimator_chk #(
    parameter int PIX_W   = 8,
    parameter int MAX_WIN = 65,
    parameter int CNT_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_factor,
    input logic             in_valid,
    input logic             in_line_start,
    input logic [PIX_W-1:0] in_luma,
    input logic             out_y_valid,
    input logic [PIX_W-1:0] out_y,
    input logic             out_cb_valid,
    input logic             out_cr_valid,
    input logic [CNT_W-1:0] win_q
);

    // R1: reset clears every strobe
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_y_valid && !out_cb_valid && !out_cr_valid));

    // R2: latched window stays in the legal range
    assert_win_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q >= CNT_W'(1)) && (win_q <= CNT_W'(MAX_WIN)));

    // R8: the window length moves only on a valid line-start sample
    assert_win_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_line_start) |=> $stable(win_q));

    // R4: factor 1 on a line start passes the luma sample through
    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_line_start && cfg_factor == CNT_W'(1))
            |=> ##1 (out_y_valid && out_y == $past(in_luma, 2)));

    // R9: luma strobe only two edges after an accepted sample
    assert_y_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_y_valid |-> $past(in_valid, 2));

    // R9: chroma strobes only two edges after an accepted sample
    assert_c_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cb_valid || out_cr_valid) |-> $past(in_valid, 2));

endmodule

bind hwin_decimator hwin_decimator_chk #(
    .PIX_W   (PIX_W),
    .MAX_WIN (MAX_WIN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_factor    (cfg_factor),
    .in_valid      (in_valid),
    .in_line_start (in_line_start),
    .in_luma       (in_luma),
    .out_y_valid   (out_y_valid),
    .out_y         (out_y),
    .out_cb_valid  (out_cb_valid),
    .out_cr_valid  (out_cr_valid),
    .win_q         (win_q)
);

// File: tb/hwin_decimator_tb.sv
// Bench for hwin_decimator: reference model with due-edge queues,
// directed corner cases and seeded random lines.
module hwin_decimator_tb;

    localparam int CLK_NS = 10;
    localparam int MAXW   = 65;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_factor = 7'd1;
    logic       in_valid = 1'b0;
    logic       in_line_start = 1'b0;
    logic       in_line_last = 1'b0;
    logic [7:0] in_luma = 8'd0;
    logic [7:0] in_chroma = 8'd0;
    logic       out_y_valid, out_cb_valid, out_cr_valid;
    logic [7:0] out_y, out_cb, out_cr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    string cur_tag = "R3";

    // reference model state
    int m_win = 1;
    int m_par = 0;
    int m_sum [3];
    int m_cnt [3];
    int qv [3][$];
    int qd [3][$];

    hwin_decimator u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_factor(cfg_factor),
        .in_valid(in_valid), .in_line_start(in_line_start), .in_line_last(in_line_last),
        .in_luma(in_luma), .in_chroma(in_chroma),
        .out_y_valid(out_y_valid), .out_y(out_y),
        .out_cb_valid(out_cb_valid), .out_cb(out_cb),
        .out_cr_valid(out_cr_valid), .out_cr(out_cr)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int clamp_win(input int f);
        if (f == 0) return 1;
        if (f > MAXW) return MAXW;
        return f;
    endfunction

    function automatic int rnd_avg(input int s, input int n);
        int q;
        q = (2 * s + n) / (2 * n);
        return (q > 255) ? 255 : q;
    endfunction

    task automatic push(input int l, input int due);
        qv[l].push_back(rnd_avg(m_sum[l], m_cnt[l]));
        qd[l].push_back(due);
        m_sum[l] = 0;
        m_cnt[l] = 0;
    endtask

    // reference step for one accepted cycle (R2 R5 R6 R7 R10)
    task automatic model_step(input bit ls, input bit ll, input int cfg,
                              input int y, input int ch, input int due);
        int cl;
        if (ls) begin
            for (int l = 0; l < 3; l++) begin m_sum[l] = 0; m_cnt[l] = 0; end
            m_par = 0;
            m_win = clamp_win(cfg);
        end
        m_sum[0] += y; m_cnt[0]++;
        if (m_cnt[0] == m_win || ll) push(0, due);
        cl = (m_par == 0) ? 1 : 2;
        m_sum[cl] += ch; m_cnt[cl]++;
        if (m_cnt[cl] == m_win || ll) push(cl, due);
        if (ll && m_cnt[3 - cl] != 0) push(3 - cl, due);
        m_par ^= 1;
    endtask

    task automatic drive(input bit v, input bit ls, input bit ll, input int y, input int ch);
        @(negedge clk);
        in_valid = v; in_line_start = ls; in_line_last = ll;
        in_luma = 8'(y); in_chroma = 8'(ch);
        @(posedge clk);
        #1;
        if (v) model_step(ls, ll, int'(cfg_factor), y, ch, cyc + 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            drive(1'b0, 1'($urandom), 1'($urandom), int'($urandom % 256), int'($urandom % 256));
    endtask

    // One line. pat: 0 random, 1 ramp, 2 all 255, 3 alternating 1/2.
    task automatic send_line(input int fac, input int len, input bit last,
                             input int gap, input int pat, input int chg_at, input int chg_fac);
        int y, c;
        cfg_factor = 7'(fac);
        for (int i = 0; i < len; i++) begin
            if (i == chg_at) cfg_factor = 7'(chg_fac);
            case (pat)
                1: begin y = (i * 7) % 256; c = (255 - i * 3) % 256; end
                2: begin y = 255; c = 255; end
                3: begin y = 1 + (i % 2); c = 1 + (i % 2); end
                default: begin y = int'($urandom % 256); c = int'($urandom % 256); end
            endcase
            if (gap > 0 && ($urandom % 100) < gap) idle(1 + int'($urandom % 3));
            drive(1'b1, i == 0, last && (i == len - 1), y, c);
        end
    endtask

    // output monitor: compare at the due edge, flag missing results
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int l = 0; l < 3; l++) begin
                logic v;
                int a;
                string t;
                v = (l == 0) ? out_y_valid : (l == 1) ? out_cb_valid : out_cr_valid;
                a = (l == 0) ? int'(out_y) : (l == 1) ? int'(out_cb) : int'(out_cr);
                t = (l == 0) ? cur_tag : "R7";
                if (v) begin
                    checks++;
                    if (qv[l].size() == 0) begin
                        fails++;
                        $display("FAIL %s/R9 lane %0d: unexpected valid, actual %0d expected none", t, l, a);
                    end else begin
                        int ev, ed;
                        ev = qv[l].pop_front();
                        ed = qd[l].pop_front();
                        if (a != ev || ed != cyc) begin
                            fails++;
                            $display("FAIL %s/R9 lane %0d: actual %0d at edge %0d, expected %0d at edge %0d",
                                     t, l, a, cyc, ev, ed);
                        end
                    end
                end else if (qd[l].size() != 0 && qd[l][0] <= cyc) begin
                    checks++;
                    fails++;
                    $display("FAIL R9 lane %0d: actual no valid at edge %0d, expected %0d", l, cyc, qv[l][0]);
                    void'(qv[l].pop_front());
                    void'(qd[l].pop_front());
                end
            end
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_NS * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < 3; l++) begin m_sum[l] = 0; m_cnt[l] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: strobes low while in reset
        checks++;
        if (out_y_valid || out_cb_valid || out_cr_valid) begin
            fails++;
            $display("FAIL R1: actual valids %b%b%b, expected 000", out_y_valid, out_cb_valid, out_cr_valid);
        end
        rst_n = 1'b1;
        idle(2);

        cur_tag = "R4"; send_line(1, 8, 1'b1, 0, 1, -1, 0);       // passthrough
        idle(3);
        cur_tag = "R2"; send_line(0, 6, 1'b1, 0, 0, -1, 0);       // 0 acts as 1
        idle(3);
        cur_tag = "R5"; send_line(3, 10, 1'b1, 0, 1, -1, 0);      // partial end windows
        idle(3);
        cur_tag = "R3"; send_line(2, 8, 1'b1, 0, 3, -1, 0);       // 1,2 -> half rounds up
        idle(3);
        cur_tag = "R3"; send_line(65, 130, 1'b1, 0, 2, -1, 0);    // full sums of 255
        idle(3);
        cur_tag = "R2"; send_line(100, 140, 1'b1, 0, 0, -1, 0);   // clamps to 65
        idle(3);
        cur_tag = "R8"; send_line(4, 20, 1'b1, 0, 1, 5, 1);       // mid-line change ignored
        idle(3);
        cur_tag = "R8"; send_line(1, 9, 1'b1, 0, 0, -1, 0);       // new factor at next line
        idle(3);
        cur_tag = "R6"; send_line(5, 7, 1'b0, 0, 0, -1, 0);       // no end marker
        cur_tag = "R6"; send_line(5, 12, 1'b1, 0, 0, -1, 0);      // partial discarded
        idle(3);
        cur_tag = "R10"; send_line(3, 15, 1'b1, 60, 0, -1, 0);    // idle gaps with junk
        idle(3);
        cur_tag = "R5"; send_line(4, 1, 1'b1, 0, 0, -1, 0);       // single-sample line
        idle(3);

        cur_tag = "R3";
        for (int k = 0; k < 40; k++) begin
            send_line(int'($urandom % 72), 1 + int'($urandom % 160),
                      ($urandom % 10) != 0, int'($urandom % 30), 0,
                      int'($urandom % 200), int'($urandom % 72));
            if ($urandom % 2) idle(1 + int'($urandom % 4));
        end
        idle(6);

        // R9: nothing left pending
        for (int l = 0; l < 3; l++) begin
            checks++;
            if (qv[l].size() != 0) begin
                fails++;
                $display("FAIL R9 lane %0d: actual %0d pending, expected 0", l, qv[l].size());
            end
        end
        summary();
    end

endmodule